// File: doc/BRIEF.md
# Interrupt Context Entry and Return Sequencer

This block carries out the memory traffic that switches a 16-bit processor into and out of an interrupt service routine. The processor keeps a descending hardware stack in memory. On entry the block saves the running status word and program counter on that stack. It then fetches a new program counter and a new status word from a two-word vector whose address the interrupting device supplies. On a return command from instruction decode it reverses the process: it pops the program counter and then the status word.

The block holds the stack pointer, program counter and status word. The rest of the core can overwrite them through a context load port while the block is idle. Memory is reached through a single word port. Each access is held until the memory answers with ready. A trace bit in the status word makes the end of every instruction enter a trap through a fixed vector, using the same save-and-fetch path. After an interrupt has been entered, a new interrupt cannot be taken until the first instruction of the routine has completed. This lets saved contexts nest to any depth on the shared stack.

Top module: `intr_seq_top`

## Requirements
- R1: Entry writes the old status word to SP-2 and then the old program counter to SP-4, as the first two accesses of the sequence.
- R2: Every push lowers SP by 2 before its write and every pop raises SP by 2 after its read, so a complete entry leaves SP-4 and a complete return leaves SP+4.
- R3: After the two pushes, entry reads the new program counter from the vector address V and then the new status word from V+2, and loads both.
- R4: Bit 0 of the device vector is ignored, so an odd vector V behaves as V-1.
- R5: A return command reads the program counter from [SP] and then the status word from [SP+2], and restores both.
- R6: Two nested entries followed by two returns bring SP, program counter and status word back to their values before the first entry.
- R7: After an interrupt entry completes, a held interrupt request starts nothing until an instruction-done pulse arrives; a request is accepted in the same cycle as that pulse.
- R8: When status bit 4 (trace) is set and instruction-done pulses while idle, an entry runs through the fixed vector 0x000C.
- R9: If starts coincide, the priority is trace, then return, then interrupt. A trace entry also blocks interrupts until the next instruction-done pulse.
- R10: A context load is applied only while the block is idle; a load while busy has no effect on SP, program counter or status word.
- R11: Busy goes high in the cycle after a start and stays high until the last access is acknowledged. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R12: While a request waits for ready, the request, write enable and address are held unchanged, and the sequence does not advance.
- R13: After reset the block is idle with no memory request, and SP, program counter and status word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Interrupt request level from the granted device |
| irqVec | input | 16 | Vector byte address supplied by the device |
| rtiReq | input | 1 | Return-from-interrupt command from decode |
| instrDone | input | 1 | Pulse when an instruction completes |
| ctxLoad | input | 1 | Load SP, PC and status from the inputs below (idle only) |
| spIn | input | 16 | Stack pointer value to load |
| pcIn | input | 16 | Program counter value to load |
| pswIn | input | 16 | Status word value to load |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address of the word accessed |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with memRdy |
| memRdy | input | 1 | Memory completes the current access |
| spOut | output | 16 | Current stack pointer |
| pcOut | output | 16 | Current program counter |
| pswOut | output | 16 | Current status word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after a sequence ends |

## Verification
The instruction-done pulse can start a trace trap in the same cycle that an armed interrupt request or a return command arrives. The bench raises these together at one clock edge while the status trace bit is set. It then reads the access log from its memory model. The third access must be the trace vector fetch, and the held interrupt must start nothing until the next instruction-done pulse. A coincident return and interrupt is judged the same way: the first logged access must be a read at SP.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSW,
    ST_PUSH_PC,
    ST_VEC_PC,
    ST_VEC_PSW,
    ST_POP_PC,
    ST_POP_PSW
  } seqState_t;

  typedef enum logic [1:0] {
    ADR_PUSH,
    ADR_POP,
    ADR_VEC,
    ADR_VEC2
  } adrSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    memReq;
    logic    memWe;
    adrSel_t adrSel;
    logic    wrPsw;
    logic    spDec;
    logic    spInc;
    logic    pcLoad;
    logic    pswLoad;
    logic    vecCapIrq;
    logic    vecCapTrap;
  } dpCtl_t;

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   irqReq,
  input  logic   rtiReq,
  input  logic   instrDone,
  input  logic   traceBit,
  input  logic   memRdy,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  seqState_t state, nxt;
  logic irqArm;
  logic idle, startTrap, startRti, startIrq, lastAck;

  always_comb begin
    idle      = (state == ST_IDLE);
    startTrap = idle && instrDone && traceBit;
    startRti  = idle && rtiReq && !startTrap;
    startIrq  = idle && irqReq && (irqArm || instrDone) && !startTrap && !startRti;
    lastAck   = memRdy && ((state == ST_VEC_PSW) || (state == ST_POP_PSW));
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (startTrap || startIrq) nxt = ST_PUSH_PSW;
        else if (startRti)         nxt = ST_POP_PC;
      end
      ST_PUSH_PSW: if (memRdy) nxt = ST_PUSH_PC;
      ST_PUSH_PC:  if (memRdy) nxt = ST_VEC_PC;
      ST_VEC_PC:   if (memRdy) nxt = ST_VEC_PSW;
      ST_VEC_PSW:  if (memRdy) nxt = ST_IDLE;
      ST_POP_PC:   if (memRdy) nxt = ST_POP_PSW;
      ST_POP_PSW:  if (memRdy) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    ctl.adrSel = ADR_PUSH;
    case (state)
      ST_PUSH_PSW: begin
        ctl.memReq = 1'b1; ctl.memWe = 1'b1; ctl.wrPsw = 1'b1;
        ctl.adrSel = ADR_PUSH; ctl.spDec = memRdy;
      end
      ST_PUSH_PC: begin
        ctl.memReq = 1'b1; ctl.memWe = 1'b1;
        ctl.adrSel = ADR_PUSH; ctl.spDec = memRdy;
      end
      ST_VEC_PC: begin
        ctl.memReq = 1'b1; ctl.adrSel = ADR_VEC; ctl.pcLoad = memRdy;
      end
      ST_VEC_PSW: begin
        ctl.memReq = 1'b1; ctl.adrSel = ADR_VEC2; ctl.pswLoad = memRdy;
      end
      ST_POP_PC: begin
        ctl.memReq = 1'b1; ctl.adrSel = ADR_POP;
        ctl.pcLoad = memRdy; ctl.spInc = memRdy;
      end
      ST_POP_PSW: begin
        ctl.memReq = 1'b1; ctl.adrSel = ADR_POP;
        ctl.pswLoad = memRdy; ctl.spInc = memRdy;
      end
      default: ;
    endcase
    ctl.vecCapIrq  = startIrq;
    ctl.vecCapTrap = startTrap;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      irqArm <= 1'b1;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= lastAck;
      if (memRdy && state == ST_VEC_PSW) irqArm <= 1'b0;
      else if (instrDone)                irqArm <= 1'b1;
    end
  end

  assign busy = !idle;

  assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memReq && !memRdy) |=> (ctl.memReq && $stable(state) && $stable(ctl.memWe)));

  assert_no_unarmed_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !irqArm && !instrDone && !rtiReq) |=> (state == ST_IDLE));

  assert_trace_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (idle && instrDone && traceBit) |=> (state == ST_PUSH_PSW));

endmodule

// File: rtl/intr_seq_dp.sv
module intr_seq_dp
  import intr_seq_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] TRACE_VEC = 16'h000C,
  parameter int              T_BIT     = 4,
  parameter logic [DATA_W-1:0] SP_RST    = '0,
  parameter logic [DATA_W-1:0] PC_RST    = '0,
  parameter logic [DATA_W-1:0] PSW_RST   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              busy,
  input  logic              memRdy,
  input  logic              ctxLoad,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] pswIn,
  input  logic [DATA_W-1:0] irqVec,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pswOut,
  output logic              traceBit
);

  localparam int STEP = DATA_W / 8;
  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic [DATA_W-1:0] spReg, pcReg, pswReg, vecReg;
  logic ctxWr;

  assign ctxWr = ctxLoad && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg  <= SP_RST;
      pcReg  <= PC_RST;
      pswReg <= PSW_RST;
    end else if (ctxWr) begin
      spReg  <= spIn;
      pcReg  <= pcIn;
      pswReg <= pswIn;
    end else begin
      if (ctl.spDec)   spReg  <= spReg - STEP_V;
      if (ctl.spInc)   spReg  <= spReg + STEP_V;
      if (ctl.pcLoad)  pcReg  <= memRdata;
      if (ctl.pswLoad) pswReg <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               vecReg <= '0;
    else if (ctl.vecCapTrap) vecReg <= {TRACE_VEC[DATA_W-1:1], 1'b0};
    else if (ctl.vecCapIrq)  vecReg <= {irqVec[DATA_W-1:1], 1'b0};
  end

  always_comb begin
    case (ctl.adrSel)
      ADR_PUSH: memAddr = spReg - STEP_V;
      ADR_POP:  memAddr = spReg;
      ADR_VEC:  memAddr = vecReg;
      default:  memAddr = vecReg + STEP_V;
    endcase
    memWdata = ctl.wrPsw ? pswReg : pcReg;
  end

  assign spOut    = spReg;
  assign pcOut    = pcReg;
  assign pswOut   = pswReg;
  assign traceBit = pswReg[T_BIT];

  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((spReg != $past(spReg)) && !$past(ctxWr)) |->
      ((spReg == $past(spReg) - STEP_V) || (spReg == $past(spReg) + STEP_V)));

  assert_vec_even_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memReq && (ctl.adrSel == ADR_VEC || ctl.adrSel == ADR_VEC2)) |-> !memAddr[0]);

  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memReq && !memRdy) |=> $stable(memAddr));

  assert_ctx_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.pcLoad) |=> $stable(pcReg));

endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
  import intr_seq_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter logic [DATA_W-1:0] TRACE_VEC = 16'h000C,
  parameter int                T_BIT     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [DATA_W-1:0] irqVec,
  input  logic              rtiReq,
  input  logic              instrDone,
  input  logic              ctxLoad,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] pswIn,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memRdy,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] pswOut,
  output logic              busy,
  output logic              done
);

  dpCtl_t ctl;
  logic   traceBit;

  intr_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .rtiReq(rtiReq),
    .instrDone(instrDone), .traceBit(traceBit), .memRdy(memRdy),
    .ctl(ctl), .busy(busy), .done(done)
  );

  intr_seq_dp #(
    .DATA_W(DATA_W), .TRACE_VEC(TRACE_VEC), .T_BIT(T_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy), .memRdy(memRdy),
    .ctxLoad(ctxLoad), .spIn(spIn), .pcIn(pcIn), .pswIn(pswIn),
    .irqVec(irqVec), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .spOut(spOut), .pcOut(pcOut), .pswOut(pswOut),
    .traceBit(traceBit)
  );

  assign memReq = ctl.memReq;
  assign memWe  = ctl.memWe;

endmodule

// File: tb/intr_seq_top_tb.sv
module intr_seq_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 1'b0, rtiReq = 1'b0, instrDone = 1'b0, ctxLoad = 1'b0;
  logic [15:0] irqVec = '0, spIn = '0, pcIn = '0, pswIn = '0;
  logic memReq, memWe, memRdy, busy, done;
  logic [15:0] memAddr, memWdata, memRdata, spOut, pcOut, pswOut;

  int checks = 0, errors = 0, cycles = 0;

  intr_seq_top dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqVec(irqVec), .rtiReq(rtiReq),
    .instrDone(instrDone), .ctxLoad(ctxLoad), .spIn(spIn), .pcIn(pcIn),
    .pswIn(pswIn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memRdy(memRdy),
    .spOut(spOut), .pcOut(pcOut), .pswOut(pswOut), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  // memory model with random wait states and an access log
  logic [15:0] mem [0:255];
  logic [15:0] logAddr [0:1023];
  logic        logWe [0:1023];
  int          logCnt = 0;
  int          waitCnt = 0;
  logic        slow = 1'b0;
  logic        pokeEn = 1'b0;
  logic [15:0] pokeAddr = '0, pokeData = '0;

  assign memRdy   = memReq && (waitCnt == 0);
  assign memRdata = mem[memAddr[8:1]];

  always @(posedge clk) begin
    if (pokeEn) mem[pokeAddr[8:1]] <= pokeData;
    if (memReq && memRdy) begin
      if (memWe) mem[memAddr[8:1]] <= memWdata;
      logAddr[logCnt & 1023] <= memAddr;
      logWe[logCnt & 1023]   <= memWe;
      logCnt  <= logCnt + 1;
      waitCnt <= slow ? 3 : int'($urandom_range(0, 2));
    end else if (memReq && waitCnt != 0) begin
      waitCnt <= waitCnt - 1;
    end
  end

  // R12 monitor: a stalled request must stay unchanged
  int   holdErr = 0;
  logic prevStall = 1'b0, prevWe = 1'b0;
  logic [15:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN && prevStall && (!memReq || memAddr != prevAddr || memWe != prevWe))
      holdErr++;
    prevStall = memReq && !memRdy;
    prevAddr  = memAddr;
    prevWe    = memWe;
  end

  function automatic logic [15:0] word(input logic [15:0] a);
    return mem[a[8:1]];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic loadCtx(input logic [15:0] s, input logic [15:0] p, input logic [15:0] w);
    @(negedge clk);
    ctxLoad = 1'b1; spIn = s; pcIn = p; pswIn = w;
    @(negedge clk);
    ctxLoad = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(done && !busy, "R11 done with busy low", {14'b0, busy, done}, 16'h0001);
    @(negedge clk);
    chk(!done, "R11 done one cycle", {15'b0, done}, 16'h0000);
  endtask

  task automatic checkEntry(input logic [15:0] s, input logic [15:0] p, input logic [15:0] w,
                            input logic [15:0] v, input int base);
    chk(spOut == s - 16'd4, "R2 entry sp", spOut, s - 16'd4);
    chk(word(s - 16'd2) == w, "R1 saved status", word(s - 16'd2), w);
    chk(word(s - 16'd4) == p, "R1 saved pc", word(s - 16'd4), p);
    chk(pcOut == word(v), "R3 new pc", pcOut, word(v));
    chk(pswOut == word(v + 16'd2), "R3 new status", pswOut, word(v + 16'd2));
    chk((logCnt - base) >= 4 && logAddr[base] == s - 16'd2 && logWe[base] &&
        logAddr[base+1] == s - 16'd4 && logWe[base+1] &&
        logAddr[base+2] == v && !logWe[base+2] &&
        logAddr[base+3] == v + 16'd2 && !logWe[base+3],
        "R1 R3 access order", logAddr[base+2], v);
  endtask

  task automatic doIrq(input logic [15:0] vec);
    logic [15:0] s, p, w;
    int base;
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    @(negedge clk);
    irqVec = vec; irqReq = 1'b1; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    waitDone();
    irqReq = 1'b0;
    checkEntry(s, p, w, {vec[15:1], 1'b0}, base);
  endtask

  task automatic doRti();
    logic [15:0] s;
    s = spOut;
    @(negedge clk);
    rtiReq = 1'b1;
    @(negedge clk);
    rtiReq = 1'b0;
    waitDone();
    chk(pcOut == word(s), "R5 restored pc", pcOut, word(s));
    chk(pswOut == word(s + 16'd2), "R5 restored status", pswOut, word(s + 16'd2));
    chk(spOut == s + 16'd4, "R2 R5 sp after return", spOut, s + 16'd4);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] s0, p0, w0, v, s, p, w;
    int base, bad;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!busy && !done && !memReq, "R13 idle after reset", {13'b0, busy, done, memReq}, 16'h0000);
    chk(spOut == 0 && pcOut == 0 && pswOut == 0, "R13 regs zero", spOut | pcOut | pswOut, 16'h0000);

    // random entries and returns (R1 R2 R3 R5)
    for (int it = 0; it < 8; it++) begin
      v = 16'(16'h0040 + 2 * $urandom_range(0, 40));
      poke(v, 16'($urandom()));
      poke(v + 16'd2, 16'($urandom()) & 16'hFFEF);
      loadCtx(16'(16'h0180 + 2 * $urandom_range(0, 56)), 16'($urandom()), 16'($urandom()) & 16'hFFEF);
      doIrq(v);
      doRti();
    end

    // R4 odd vector
    poke(16'h0050, 16'h5A5A); poke(16'h0052, 16'h0003);
    loadCtx(16'h01F0, 16'h1111, 16'h0001);
    doIrq(16'h0051);
    chk(pcOut == 16'h5A5A, "R4 odd vector pc", pcOut, 16'h5A5A);

    // R6 nesting
    poke(16'h0040, 16'hA000); poke(16'h0042, 16'h00A0);
    poke(16'h0044, 16'hB000); poke(16'h0046, 16'h00C0);
    loadCtx(16'h01F0, 16'h1234, 16'h0008);
    s0 = spOut; p0 = pcOut; w0 = pswOut;
    doIrq(16'h0040);
    doIrq(16'h0044);
    chk(spOut == s0 - 16'd8, "R6 two frames deep", spOut, s0 - 16'd8);
    doRti();
    doRti();
    chk(spOut == s0 && pcOut == p0 && pswOut == w0, "R6 context back", pcOut, p0);

    // R7 unarmed interrupt held
    doIrq(16'h0040);
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    @(negedge clk);
    irqVec = 16'h0044; irqReq = 1'b1;
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (busy || memReq) bad++;
    end
    chk(bad == 0, "R7 no start before instr done", 16'(bad), 16'h0000);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    chk(busy, "R7 R11 start with instr done", {15'b0, busy}, 16'h0001);
    waitDone();
    irqReq = 1'b0;
    checkEntry(s, p, w, 16'h0044, base);

    // R8 trace trap
    poke(16'h000C, 16'h2000); poke(16'h000E, 16'h0000);
    loadCtx(16'h01E0, 16'h3000, 16'h0010);
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    @(negedge clk);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    waitDone();
    checkEntry(s, p, w, 16'h000C, base);
    chk(pcOut == 16'h2000, "R8 trace vector pc", pcOut, 16'h2000);

    // R9 trace and interrupt in the same cycle
    poke(16'h0080, 16'h4400); poke(16'h0082, 16'h0002);
    loadCtx(16'h01E0, 16'h3100, 16'h0010);
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    @(negedge clk);
    irqVec = 16'h0080; irqReq = 1'b1; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    waitDone();
    chk(logAddr[base+2] == 16'h000C, "R9 trace before irq", logAddr[base+2], 16'h000C);
    checkEntry(s, p, w, 16'h000C, base);
    bad = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (busy) bad++;
    end
    chk(bad == 0, "R9 irq held after trace", 16'(bad), 16'h0000);
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    waitDone();
    irqReq = 1'b0;
    checkEntry(s, p, w, 16'h0080, base);

    // R9 return wins over interrupt
    poke(16'h0090, 16'h6600); poke(16'h0092, 16'h0004);
    @(negedge clk);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    s = spOut; base = logCnt;
    irqVec = 16'h0090; irqReq = 1'b1; rtiReq = 1'b1;
    @(negedge clk);
    rtiReq = 1'b0;
    waitDone();
    chk(logAddr[base] == s && !logWe[base], "R9 return first", logAddr[base], s);
    chk(spOut == s + 16'd4 || busy, "R9 R5 return completed", spOut, s + 16'd4);
    while (!done) @(negedge clk);
    irqReq = 1'b0;
    chk(logWe[base+2] && logAddr[base+6-2] == 16'h0090, "R9 irq after return", logAddr[base+4], 16'h0090);
    @(negedge clk);

    // R10 context load ignored while busy, R12 with long waits
    slow = 1'b1;
    loadCtx(16'h01C0, 16'h7777, 16'h0000);
    s = spOut; p = pcOut; w = pswOut; base = logCnt;
    @(negedge clk);
    irqVec = 16'h0040; irqReq = 1'b1; instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
    @(negedge clk);
    ctxLoad = 1'b1; spIn = 16'h0100; pcIn = 16'hDEAD; pswIn = 16'hBEEF;
    @(negedge clk);
    ctxLoad = 1'b0;
    waitDone();
    irqReq = 1'b0;
    chk(spOut == s - 16'd4, "R10 sp unaffected by busy load", spOut, s - 16'd4);
    checkEntry(s, p, w, 16'h0040, base);
    chk(logCnt - base == 4, "R12 one log entry per access", 16'(logCnt - base), 16'd4);
    slow = 1'b0;
    chk(holdErr == 0, "R12 stalled request held", 16'(holdErr), 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule